// File: doc/BRIEF.md
# Vendor Request Register Bridge

This block sits behind a control-transfer decoder that has already pulled the request type, request code and length out of each setup packet. It turns each request into an access to a small serial-port register set: a baud divisor, a line control byte, a modem control byte and a flag that makes the transmitter wait for CTS. One request code is a placeholder. It is accepted and its byte is thrown away. Write payload arrives as a byte stream after the request is taken. Every request ends in exactly one response pulse, which carries either read data or a stall flag.

The block also keeps the modem status byte and the line status byte. Modem status holds the registered modem lines plus sticky change flags. Line status holds sticky receive error flags plus live transmitter and receiver levels. When a change flag or an error flag goes from clear to set, a two-byte status report is raised for an interrupt endpoint, with modem status first. While a report is waiting, later changes are folded into that same report.

Top module: `vreq_uart_bridge`

## Requirements
- R1: `req_ready` is high only when the block is idle. Every accepted request produces exactly one single-cycle `rsp_valid` pulse. Payload bytes are consumed only while `dat_ready` is high.
- R2: Type 0x40, code 5, length 4 takes four payload bytes, least significant first. The bytes are committed to `baud_div` at the last byte, and the response follows in the next cycle. The host supplies 115200 divided by the baud rate.
- R3: Type 0x40, code 7, length 1 writes `lcr_q`. Type 0xC0, code 6, length 1 returns `lcr_q` on `rsp_byte`.
- R4: Type 0x40, code 10, length 1 writes `mcr_q`.
- R5: Type 0x40, code 12, length 1 sets `cts_gate` to payload bit 0. A value of 1 holds transmission until CTS is asserted; a value of 0 lets it run freely.
- R6: Type 0x40, code 11, length 1 consumes its byte, responds without stall, and changes no output.
- R7: Any other type, any other code, or a length that does not fit the code gives `rsp_stall` high in the cycle after acceptance. No payload is consumed and no register changes.
- R8: The modem status byte has these fields:
  - [7:4] is the registered `modem_in` = {cd, ri, dsr, cts}.
  - [3] is set when cd changes, [2] when ri goes from 1 to 0, [1] when dsr changes, and [0] when cts changes.
  - The change flags stay set until a type 0xC0, code 2, length 1 read. That read returns the byte as it was before clearing.
- R9: The line status byte has these fields:
  - [7] is the OR of the sticky bi, fe and pe flags.
  - [6] = temt and [5] = thre, both live.
  - [4:1] are the sticky {bi, fe, pe, oe} flags, set by pulses on `line_err[3:0]`.
  - [0] = dr, live.
  - The sticky flags clear when a report is accepted.
- R10: `rpt_data` = {modem status, line status}, so modem status is the first byte. `rpt_valid` rises one cycle after any change or error flag goes from 0 to 1 and stays high until `rpt_ready`. Changes that arrive while a report is pending merge into its live content; no second report is queued.
- R11: After reset, `baud_div` = RST_DIV (12), `lcr_q` = RST_LCR (0x03), `mcr_q` = 0, `cts_gate` = 0, and no report is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Setup fields valid |
| req_ready | output | 1 | Block idle, request taken |
| req_type | input | 8 | Request type |
| req_code | input | 8 | Request code |
| req_len | input | 16 | Payload length |
| dat_valid | input | 1 | Payload byte valid |
| dat_ready | output | 1 | Payload byte taken |
| dat_byte | input | 8 | Payload byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_stall | output | 1 | Request rejected |
| rsp_byte | output | 8 | Read data |
| modem_in | input | 4 | {cd, ri, dsr, cts} lines |
| line_err | input | 4 | {bi, fe, pe, oe} event pulses |
| line_lvl | input | 3 | {temt, thre, dr} levels |
| rpt_valid | output | 1 | Status report pending |
| rpt_ready | input | 1 | Report taken |
| rpt_data | output | 16 | {modem status, line status} |
| baud_div | output | 32 | Baud divisor |
| lcr_q | output | 8 | Line control byte |
| mcr_q | output | 8 | Modem control byte |
| cts_gate | output | 1 | Hold transmit until CTS |

## Verification
The assertions check four things on every cycle:
- Each response is a single pulse.
- A rejected request leaves every register untouched.
- A register changes only in a cycle with a non-stalled response.
- A pending report is held until taken, and any new change or error flag is accompanied by a pending report.

Only the bench scenarios can show the rest: field placement and byte order in the divisor, the exact returned read values, the falling-edge-only rule for the ring change flag, merging of several changes into one report, and clearing on MSR read or report hand-off.

// File: rtl/vreq_uart_bridge.sv
module vreq_uart_bridge #(
  parameter int DIV_BYTES = 4,
  parameter logic [8*DIV_BYTES-1:0] RST_DIV = 12,
  parameter logic [7:0] RST_LCR = 8'h03
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [7:0]             req_type,
  input  logic [7:0]             req_code,
  input  logic [15:0]            req_len,
  input  logic                   dat_valid,
  output logic                   dat_ready,
  input  logic [7:0]             dat_byte,
  output logic                   rsp_valid,
  output logic                   rsp_stall,
  output logic [7:0]             rsp_byte,
  input  logic [3:0]             modem_in,
  input  logic [3:0]             line_err,
  input  logic [2:0]             line_lvl,
  output logic                   rpt_valid,
  input  logic                   rpt_ready,
  output logic [15:0]            rpt_data,
  output logic [8*DIV_BYTES-1:0] baud_div,
  output logic [7:0]             lcr_q,
  output logic [7:0]             mcr_q,
  output logic                   cts_gate
);
  localparam int DIV_W = 8 * DIV_BYTES;
  localparam int CW = (DIV_BYTES > 1) ? $clog2(DIV_BYTES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_RSP} st_t;
  st_t st;

  logic [CW-1:0]      cnt;
  logic [7:0]         code_q;
  logic [DIV_W-9:0]   pay;
  logic [3:0]         mq, dlt, err;
  logic               pend;

  assign req_ready = (st == S_IDLE);
  assign dat_ready = (st == S_DATA);
  assign rsp_valid = (st == S_RSP);

  wire acc   = req_valid && req_ready;
  wire len1  = (req_len == 16'd1);
  wire wr_ok = (req_type == 8'h40) &&
               ((req_code == 8'd5 && req_len == 16'(DIV_BYTES)) ||
                (len1 && (req_code == 8'd7 || req_code == 8'd10 ||
                          req_code == 8'd11 || req_code == 8'd12)));
  wire rd_ok = (req_type == 8'hC0) && len1 && (req_code == 8'd6 || req_code == 8'd2);
  wire rd_msr = acc && rd_ok && (req_code == 8'd2);
  wire last  = (code_q == 8'd5) ? (cnt == CW'(DIV_BYTES - 1)) : 1'b1;
  wire take  = dat_valid && dat_ready;

  wire [3:0] nd    = {modem_in[3] ^ mq[3], mq[2] & ~modem_in[2],
                      modem_in[1] ^ mq[1], modem_in[0] ^ mq[0]};
  wire [3:0] dbase = rd_msr ? 4'd0 : dlt;
  wire [3:0] ebase = (pend && rpt_ready) ? 4'd0 : err;
  wire       rise  = |(nd & ~dbase) || |(line_err & ~ebase);

  wire [7:0] msr = {mq, dlt};
  wire [7:0] lsr = {|err[3:1], line_lvl[2:1], err, line_lvl[0]};
  assign rpt_data  = {msr, lsr};
  assign rpt_valid = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; code_q <= '0; pay <= '0;
      baud_div <= RST_DIV; lcr_q <= RST_LCR; mcr_q <= '0; cts_gate <= 1'b0;
      rsp_stall <= 1'b0; rsp_byte <= '0;
      mq <= '0; dlt <= '0; err <= '0; pend <= 1'b0;
    end else begin
      mq   <= modem_in;
      dlt  <= dbase | nd;
      err  <= ebase | line_err;
      pend <= (pend && !rpt_ready) || rise;
      case (st)
        S_IDLE: if (acc) begin
          code_q <= req_code; cnt <= '0; rsp_byte <= '0; rsp_stall <= 1'b0;
          if (wr_ok) st <= S_DATA;
          else begin
            st <= S_RSP;
            rsp_stall <= !rd_ok;
            if (rd_ok) rsp_byte <= (req_code == 8'd6) ? lcr_q : msr;
          end
        end
        S_DATA: if (take) begin
          cnt <= cnt + 1'b1;
          pay <= {dat_byte, pay[DIV_W-9:8]};
          if (last) begin
            st <= S_RSP;
            case (code_q)
              8'd5:  baud_div <= {dat_byte, pay};
              8'd7:  lcr_q <= dat_byte;
              8'd10: mcr_q <= dat_byte;
              8'd12: cts_gate <= dat_byte[0];
              default: ;
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R1
  AST_REG_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({baud_div, lcr_q, mcr_q, cts_gate}) |-> (rsp_valid && !rsp_stall)); // R1
  AST_STALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wr_ok && !rd_ok) |=> (rsp_stall && $stable({baud_div, lcr_q, mcr_q, cts_gate}))); // R7
  AST_RPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && !rpt_ready) |=> rpt_valid); // R10
  AST_DELTA_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|rpt_data[11:8]) |-> rpt_valid); // R8
  AST_ERR_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|rpt_data[4:1]) |-> rpt_valid); // R9
endmodule

// File: tb/sim_vreq_uart_bridge.sv
module sim_vreq_uart_bridge;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, dat_valid = 0, rpt_ready = 0;
  logic [7:0] req_type = 0, req_code = 0, dat_byte = 0;
  logic [15:0] req_len = 0;
  logic [3:0] modem_in = 0, line_err = 0;
  logic [2:0] line_lvl = 0;
  logic req_ready, dat_ready, rsp_valid, rsp_stall, rpt_valid, cts_gate;
  logic [7:0] rsp_byte, lcr_q, mcr_q;
  logic [15:0] rpt_data;
  logic [31:0] baud_div;

  vreq_uart_bridge u0 (.clk, .rst_n, .req_valid, .req_ready, .req_type, .req_code,
    .req_len, .dat_valid, .dat_ready, .dat_byte, .rsp_valid, .rsp_stall, .rsp_byte,
    .modem_in, .line_err, .line_lvl, .rpt_valid, .rpt_ready, .rpt_data,
    .baud_div, .lcr_q, .mcr_q, .cts_gate);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0, rd_f = 0;
  logic [31:0] eb = 12;
  logic [7:0] el = 8'h03, em = 0;
  logic ec = 0;
  logic [3:0] m_mq = 0, m_d = 0, m_err = 0;
  logic m_pend = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [3:0] nd, db, eb_;
    if (!rst_n) begin
      m_mq = 0; m_d = 0; m_err = 0; m_pend = 0;
    end else begin
      nd  = {modem_in[3] ^ m_mq[3], m_mq[2] & ~modem_in[2],
             modem_in[1] ^ m_mq[1], modem_in[0] ^ m_mq[0]};
      db  = rd_f ? 4'd0 : m_d;
      eb_ = (m_pend && rpt_ready) ? 4'd0 : m_err;
      m_pend = (m_pend && !rpt_ready) || (|(nd & ~db)) || (|(line_err & ~eb_));
      m_d = db | nd; m_err = eb_ | line_err; m_mq = modem_in;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    logic [7:0] xl;
    xl = {|m_err[3:1], line_lvl[2:1], m_err, line_lvl[0]};
    chk(baud_div == eb, "R2 baud_div", baud_div, eb);
    chk(lcr_q == el, "R3 lcr_q", lcr_q, el);
    chk(mcr_q == em, "R4 mcr_q", mcr_q, em);
    chk(cts_gate == ec, "R5 cts_gate", cts_gate, ec);
    chk(rpt_valid == m_pend, "R10 rpt_valid", rpt_valid, m_pend);
    chk(rpt_data[15:8] == {m_mq, m_d}, "R8 modem status", rpt_data[15:8], {m_mq, m_d});
    chk(rpt_data[7:0] == xl, "R9 line status", rpt_data[7:0], xl);
  end

  task automatic do_req(input [7:0] t, input [7:0] c, input [15:0] l, input int nb,
                        input [31:0] data, input bit xs, input [7:0] xb, input string tag);
    logic [7:0] exp_b;
    exp_b = xb;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready idle", req_ready, 1);
    req_valid = 1; req_type = t; req_code = c; req_len = l;
    if (t == 8'hC0 && c == 8'd2 && l == 16'd1) begin
      rd_f = 1; exp_b = {m_mq, m_d};
    end
    @(posedge clk); #1;
    req_valid = 0; rd_f = 0;
    for (int i = 0; i < nb; i++) begin
      dat_valid = 1; dat_byte = data[8*i +: 8];
      @(posedge clk); #1;
      dat_valid = 0;
    end
    if (!xs && t == 8'h40) begin
      case (c)
        8'd5:  eb = data;
        8'd7:  el = data[7:0];
        8'd10: em = data[7:0];
        8'd12: ec = data[0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk(rsp_valid == 1, {tag, " rsp_valid"}, rsp_valid, 1);
    chk(rsp_stall == xs, {tag, " rsp_stall"}, rsp_stall, xs);
    if (xs) chk(dat_ready == 0, {tag, " no payload"}, dat_ready, 0);
    if (t == 8'hC0 && !xs) chk(rsp_byte == exp_b, {tag, " rsp_byte"}, rsp_byte, exp_b);
    @(negedge clk);
    chk(rsp_valid == 0, "R1 single pulse", rsp_valid, 0);
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(baud_div == 12, "R11 reset baud", baud_div, 12);
    chk(lcr_q == 8'h03, "R11 reset lcr", lcr_q, 3);
    chk(mcr_q == 0 && cts_gate == 0, "R11 reset mcr/cts", {mcr_q, cts_gate}, 0);
    chk(rpt_valid == 0, "R11 no report", rpt_valid, 0);

    do_req(8'h40, 8'd7, 1, 1, 32'h1B, 0, 0, "R3 write");
    do_req(8'hC0, 8'd6, 1, 0, 0, 0, 8'h1B, "R3 read");
    do_req(8'h40, 8'd5, 4, 4, 32'd12, 0, 0, "R2 9600");
    do_req(8'h40, 8'd5, 4, 4, 32'h12345678, 0, 0, "R2 order");
    chk(baud_div == 32'h12345678, "R2 byte order", baud_div, 32'h12345678);
    do_req(8'h40, 8'd5, 4, 4, 32'd1, 0, 0, "R2 115200");
    do_req(8'h40, 8'd10, 1, 1, 32'h0B, 0, 0, "R4");
    do_req(8'h40, 8'd12, 1, 1, 32'h01, 0, 0, "R5 gate");
    chk(cts_gate == 1, "R5 gate on", cts_gate, 1);
    do_req(8'h40, 8'd12, 1, 1, 32'h02, 0, 0, "R5 free");
    chk(cts_gate == 0, "R5 gate off", cts_gate, 0);
    do_req(8'h40, 8'd11, 1, 1, 32'hFF, 0, 0, "R6");
    chk({lcr_q, mcr_q} == 16'h1B0B, "R6 no effect", {lcr_q, mcr_q}, 16'h1B0B);

    dat_valid = 1; dat_byte = 8'hEE;
    do_req(8'h40, 8'd9, 1, 0, 0, 1, 0, "R7 code");
    do_req(8'h40, 8'd7, 2, 0, 0, 1, 0, "R7 len");
    do_req(8'hC0, 8'd6, 2, 0, 0, 1, 0, "R7 rdlen");
    do_req(8'h21, 8'd7, 1, 0, 0, 1, 0, "R7 type");
    do_req(8'h40, 8'd5, 1, 0, 0, 1, 0, "R7 baudlen");
    dat_valid = 0;
    do_req(8'hC0, 8'd6, 1, 0, 0, 0, 8'h1B, "R7 lcr kept");

    line_lvl = 3'b111;
    modem_in = 4'b0001; step();
    @(negedge clk);
    chk(rpt_valid == 1, "R10 raised", rpt_valid, 1);
    chk(rpt_data[15:8] == 8'h11, "R8 cts change", rpt_data[15:8], 8'h11);
    step(); modem_in = 4'b0011; step();
    @(negedge clk);
    chk(rpt_data[15:8] == 8'h33, "R10 merge", rpt_data[15:8], 8'h33);
    rpt_ready = 1; step(); rpt_ready = 0;
    @(negedge clk);
    chk(rpt_valid == 0, "R10 taken", rpt_valid, 0);
    chk(rpt_data[11:8] == 4'h3, "R8 sticky", rpt_data[11:8], 3);
    do_req(8'hC0, 8'd2, 1, 0, 0, 0, 8'h33, "R8 msr read");
    chk(rpt_data[11:8] == 0, "R8 cleared", rpt_data[11:8], 0);

    modem_in = 4'b0111; step();
    @(negedge clk);
    chk(rpt_valid == 0 && rpt_data[11:8] == 0, "R8 ri rise ignored", rpt_data[11:8], 0);
    step(); modem_in = 4'b0011; step();
    @(negedge clk);
    chk(rpt_data[15:8] == 8'h34 && rpt_valid, "R8 ri fall", rpt_data[15:8], 8'h34);
    rpt_ready = 1; step(); rpt_ready = 0;
    do_req(8'hC0, 8'd2, 1, 0, 0, 0, 0, "R8 msr read2");

    line_err = 4'b0010; step(); line_err = 0;
    @(negedge clk);
    chk(rpt_valid == 1 && rpt_data[7:0] == 8'hE5, "R9 parity", rpt_data[7:0], 8'hE5);
    step(); line_err = 4'b0001; step(); line_err = 0;
    @(negedge clk);
    chk(rpt_data[7:0] == 8'hE7, "R9 merged", rpt_data[7:0], 8'hE7);
    rpt_ready = 1; step(); rpt_ready = 0;
    @(negedge clk);
    chk(rpt_data[7:0] == 8'h61 && !rpt_valid, "R9 cleared", rpt_data[7:0], 8'h61);
    step(); line_err = 4'b0001; step(); line_err = 0;
    @(negedge clk);
    chk(rpt_data[7:0] == 8'h63, "R9 overrun only", rpt_data[7:0], 8'h63);
    rpt_ready = 1; step(); rpt_ready = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule